// File: doc/BRIEF.md
# ECC Read Error Response Policy

This block sits behind the ECC decoder of a memory controller and decides what happens to every checked read. Each read carries a source (a demand read from a requester, a background patrol scrub read, or a read made while copying a failing rank onto its spare) and the error class the decoder reported (clean, correctable or uncorrectable). From these two inputs the block drives a response to the requester, a write to memory, a re-read request, an error-log strobe with an error code, and the address of the access.

An uncorrectable result on a demand or patrol read is not trusted the first time. The block keeps one retry bit per request tag and asks for the same read once more. Only a second uncorrectable result on that tag counts as persistent. A persistent demand error returns a poisoned response. A persistent patrol error is only logged. A spare-copy read is never retried: an uncorrectable word is replaced by a fixed poison marker in the spare location. Poisoned data is all zeros except the low 24 bits, which hold 0xFF00FF.

With demand scrubbing enabled, correctable demand data is also written back to memory, and each demand response takes one extra cycle.

Top module: `ecc_resp_policy`

## Requirements
- R1: After reset, and in every cycle where no read was captured on the previous edge, rsp_valid, wr_valid, reissue_valid and log_valid are all low (encodings: rd_src 0 demand, 1 patrol, 2 spare copy; rd_cls 0 clean, 1 correctable, 2 or 3 uncorrectable).
- R2: A clean demand read gives rsp_valid with rd_data and the request tag, rsp_poison low, no log and no write, one cycle after capture when dscrub_en is low.
- R3: A correctable demand read returns the decoder's corrected rd_data with rsp_poison low and logs code 14. It writes that data back to memory only when dscrub_en is high.
- R4: With dscrub_en high, every demand response appears two cycles after capture instead of one. dscrub_en changes only while no demand read is in flight.
- R5: A clean patrol read produces no output. A correctable patrol read writes rd_data back (wr_poison low) and logs code 16.
- R6: Every spare-copy read produces a write one cycle after capture. A clean one writes rd_data with no log. A correctable one writes rd_data and logs code 15.
- R7: The first uncorrectable demand or patrol read of a tag raises reissue_valid with the same source and tag, and gives no response, no write and no log.
- R8: A second uncorrectable demand read on a retried tag gives a response with rsp_poison high and the poison word as data, and logs code 10. It writes nothing. The poison word is zero except bits [23:0] = 0xFF00FF.
- R9: A second uncorrectable patrol read on a retried tag logs code 12, with no write and no response.
- R10: An uncorrectable spare-copy read writes the poison word with wr_poison high, logs code 11, and never re-issues.
- R11: Retry state is held per tag. A re-read that returns clean or correctable data is handled as that class and clears the tag's state. Other tags are unaffected.
- R12: In any cycle with wr_valid, reissue_valid or log_valid high, act_rank, act_bank, act_row and act_col show the rank, bank, row and column of the access that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dscrub_en | input | 1 | Demand scrub enable (write-back and extra response cycle) |
| rd_valid | input | 1 | A checked read result is present |
| rd_src | input | 2 | Read source: 0 demand, 1 patrol, 2 spare copy |
| rd_cls | input | 2 | Error class: 0 clean, 1 correctable, 2/3 uncorrectable |
| rd_tag | input | TAG_W | Request tag |
| rd_data | input | DATA_W | Decoder output data (corrected when correctable) |
| rd_rank | input | RANK_W | Rank of the access |
| rd_bank | input | BANK_W | Bank of the access |
| rd_row | input | ROW_W | Row of the access |
| rd_col | input | COL_W | Column of the access |
| rsp_valid | output | 1 | Response to requester |
| rsp_tag | output | TAG_W | Tag of the response |
| rsp_data | output | DATA_W | Response data |
| rsp_poison | output | 1 | Response is poisoned |
| wr_valid | output | 1 | Memory write request |
| wr_poison | output | 1 | Write carries the poison word |
| wr_data | output | DATA_W | Write data |
| reissue_valid | output | 1 | Re-read request |
| reissue_src | output | 2 | Source of the re-read |
| reissue_tag | output | TAG_W | Tag of the re-read |
| log_valid | output | 1 | Error log strobe |
| log_code | output | 5 | Error code |
| act_rank | output | RANK_W | Rank of the access behind write, re-read or log |
| act_bank | output | BANK_W | Bank of that access |
| act_row | output | ROW_W | Row of that access |
| act_col | output | COL_W | Column of that access |

## Verification
The only hidden state is the retry bit of each tag. If a bit is wrongly set or left uncleared, the next uncorrectable read on that tag skips its re-read and is poisoned or logged at once. If a bit is never set, re-reads repeat and nothing is ever logged. Both faults show on reissue_valid and log_valid one cycle after that second read. The bench therefore interleaves tags: a clean re-read must clear a bit, and the following uncorrectable read must again give a re-issue rather than a poison. A wrong response stage shows as the response landing one cycle early or late, which the per-cycle scoreboard catches on the first demand read after the enable changes.

// File: rtl/ecc_resp_pkg.sv
package ecc_resp_pkg;

   localparam int CODE_W = 5;

   typedef enum logic [1:0] {
      SRC_DEMAND = 2'd0,
      SRC_PATROL = 2'd1,
      SRC_SPARE  = 2'd2,
      SRC_NONE   = 2'd3
   } rd_src_e;

   localparam logic [CODE_W-1:0] CODE_DMD_UC = 5'd10;
   localparam logic [CODE_W-1:0] CODE_SPR_UC = 5'd11;
   localparam logic [CODE_W-1:0] CODE_PAT_UC = 5'd12;
   localparam logic [CODE_W-1:0] CODE_DMD_CE = 5'd14;
   localparam logic [CODE_W-1:0] CODE_SPR_CE = 5'd15;
   localparam logic [CODE_W-1:0] CODE_PAT_CE = 5'd16;

   localparam logic [23:0] POISON_LOW = 24'hFF00FF;

   typedef struct packed {
      logic              rsp;
      logic              rsp_psn;
      logic              wr;
      logic              wr_psn;
      logic              reissue;
      logic              log;
      logic [CODE_W-1:0] code;
      logic              set_retry;
      logic              clr_retry;
   } action_t;

endpackage

// File: rtl/ecc_retry_table.sv
module ecc_retry_table #(
   parameter int NUM_TAGS = 16,
   localparam int TAG_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] tag,
   input  logic             set_bit,
   input  logic             clr_bit,
   output logic             retried
);

   logic [NUM_TAGS-1:0] pend_q;

   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[t] <= 1'b0;
         end else if (tag == TAG_W'(t)) begin
            if (set_bit)      pend_q[t] <= 1'b1;
            else if (clr_bit) pend_q[t] <= 1'b0;
         end
      end
   end

   assign retried = pend_q[tag];

endmodule

// File: rtl/ecc_policy_decide.sv
module ecc_policy_decide
   import ecc_resp_pkg::*;
(
   input  logic       valid,
   input  logic [1:0] src,
   input  logic [1:0] cls,
   input  logic       retried,
   input  logic       dscrub_en,
   output action_t    act
);

   logic uc, ce;
   assign uc = cls[1];
   assign ce = (cls == 2'b01);

   always_comb begin
      act = '0;
      if (valid) begin
         case (rd_src_e'(src))
            SRC_DEMAND: begin
               if (!uc) begin
                  act.rsp       = 1'b1;
                  act.clr_retry = retried;
                  if (ce) begin
                     act.log  = 1'b1;
                     act.code = CODE_DMD_CE;
                     act.wr   = dscrub_en;
                  end
               end else if (!retried) begin
                  act.reissue   = 1'b1;
                  act.set_retry = 1'b1;
               end else begin
                  act.rsp       = 1'b1;
                  act.rsp_psn   = 1'b1;
                  act.log       = 1'b1;
                  act.code      = CODE_DMD_UC;
                  act.clr_retry = 1'b1;
               end
            end
            SRC_PATROL: begin
               if (!uc) begin
                  act.clr_retry = retried;
                  if (ce) begin
                     act.wr   = 1'b1;
                     act.log  = 1'b1;
                     act.code = CODE_PAT_CE;
                  end
               end else if (!retried) begin
                  act.reissue   = 1'b1;
                  act.set_retry = 1'b1;
               end else begin
                  act.log       = 1'b1;
                  act.code      = CODE_PAT_UC;
                  act.clr_retry = 1'b1;
               end
            end
            SRC_SPARE: begin
               act.wr        = 1'b1;
               act.clr_retry = retried;
               if (uc) begin
                  act.wr_psn = 1'b1;
                  act.log    = 1'b1;
                  act.code   = CODE_SPR_UC;
               end else if (ce) begin
                  act.log  = 1'b1;
                  act.code = CODE_SPR_CE;
               end
            end
            default: act = '0;
         endcase
      end
   end

endmodule

// File: rtl/ecc_resp_policy.sv
module ecc_resp_policy
   import ecc_resp_pkg::*;
#(
   parameter int DATA_W       = 256,
   parameter int NUM_TAGS     = 16,
   parameter int RANK_W       = 3,
   parameter int BANK_W       = 3,
   parameter int ROW_W        = 16,
   parameter int COL_W        = 11,
   parameter bit DSCRUB_STAGE = 1'b1,
   localparam int TAG_W = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dscrub_en,
   input  logic              rd_valid,
   input  logic [1:0]        rd_src,
   input  logic [1:0]        rd_cls,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [RANK_W-1:0] rd_rank,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [ROW_W-1:0]  rd_row,
   input  logic [COL_W-1:0]  rd_col,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_poison,
   output logic              wr_valid,
   output logic              wr_poison,
   output logic [DATA_W-1:0] wr_data,
   output logic              reissue_valid,
   output logic [1:0]        reissue_src,
   output logic [TAG_W-1:0]  reissue_tag,
   output logic              log_valid,
   output logic [4:0]        log_code,
   output logic [RANK_W-1:0] act_rank,
   output logic [BANK_W-1:0] act_bank,
   output logic [ROW_W-1:0]  act_row,
   output logic [COL_W-1:0]  act_col
);

   localparam logic [DATA_W-1:0] POISON_WORD = {{(DATA_W-24){1'b0}}, POISON_LOW};

   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and at least 32");
   end
   if (NUM_TAGS < 2 || (1 << TAG_W) != NUM_TAGS) begin : g_bad_tags
      $error("NUM_TAGS must be a power of two, at least 2");
   end

   logic    retried;
   action_t act;

   ecc_retry_table #(.NUM_TAGS(NUM_TAGS)) i_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .tag     (rd_tag),
      .set_bit (act.set_retry),
      .clr_bit (act.clr_retry),
      .retried (retried)
   );

   ecc_policy_decide i_decide (
      .valid     (rd_valid),
      .src       (rd_src),
      .cls       (rd_cls),
      .retried   (retried),
      .dscrub_en (dscrub_en),
      .act       (act)
   );

   logic              s1_rsp_v, s1_rsp_p;
   logic [TAG_W-1:0]  s1_rsp_tag;
   logic [DATA_W-1:0] s1_rsp_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_rsp_v      <= 1'b0;
         s1_rsp_p      <= 1'b0;
         s1_rsp_tag    <= '0;
         s1_rsp_data   <= '0;
         wr_valid      <= 1'b0;
         wr_poison     <= 1'b0;
         wr_data       <= '0;
         reissue_valid <= 1'b0;
         reissue_src   <= '0;
         reissue_tag   <= '0;
         log_valid     <= 1'b0;
         log_code      <= '0;
         act_rank      <= '0;
         act_bank      <= '0;
         act_row       <= '0;
         act_col       <= '0;
      end else begin
         s1_rsp_v      <= act.rsp;
         s1_rsp_p      <= act.rsp_psn;
         s1_rsp_tag    <= rd_tag;
         s1_rsp_data   <= act.rsp_psn ? POISON_WORD : rd_data;
         wr_valid      <= act.wr;
         wr_poison     <= act.wr_psn;
         wr_data       <= act.wr_psn ? POISON_WORD : rd_data;
         reissue_valid <= act.reissue;
         reissue_src   <= rd_src;
         reissue_tag   <= rd_tag;
         log_valid     <= act.log;
         log_code      <= act.code;
         if (rd_valid) begin
            act_rank <= rd_rank;
            act_bank <= rd_bank;
            act_row  <= rd_row;
            act_col  <= rd_col;
         end
      end
   end

   if (DSCRUB_STAGE) begin : g_corr_stage
      logic              s2_v, s2_p;
      logic [TAG_W-1:0]  s2_tag;
      logic [DATA_W-1:0] s2_data;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_p    <= 1'b0;
            s2_tag  <= '0;
            s2_data <= '0;
         end else begin
            s2_v    <= s1_rsp_v;
            s2_p    <= s1_rsp_p;
            s2_tag  <= s1_rsp_tag;
            s2_data <= s1_rsp_data;
         end
      end

      assign rsp_valid  = dscrub_en ? s2_v    : s1_rsp_v;
      assign rsp_poison = dscrub_en ? s2_p    : s1_rsp_p;
      assign rsp_tag    = dscrub_en ? s2_tag  : s1_rsp_tag;
      assign rsp_data   = dscrub_en ? s2_data : s1_rsp_data;
   end else begin : g_no_stage
      assign rsp_valid  = s1_rsp_v;
      assign rsp_poison = s1_rsp_p;
      assign rsp_tag    = s1_rsp_tag;
      assign rsp_data   = s1_rsp_data;
   end

endmodule

// File: rtl/ecc_resp_policy_chk.sv
module ecc_resp_policy_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dscrub_en,
   input logic       rd_valid,
   input logic [1:0] rd_src,
   input logic [1:0] rd_cls,
   input logic       rsp_valid,
   input logic       rsp_poison,
   input logic       wr_valid,
   input logic       wr_poison,
   input logic       reissue_valid,
   input logic [1:0] reissue_src,
   input logic       log_valid,
   input logic [4:0] log_code
);

   a_r1_known_log_code: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> (log_code == 5'd10 || log_code == 5'd11 || log_code == 5'd12 ||
                     log_code == 5'd14 || log_code == 5'd15 || log_code == 5'd16));

   a_r5_patrol_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_src == 2'd1 && rd_cls == 2'd0) |=>
         (!log_valid && !wr_valid && !reissue_valid));

   a_r6_spare_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_src == 2'd2) |=> wr_valid);

   a_r7_reissue_alone: assert property (@(posedge clk) disable iff (!rst_n)
      reissue_valid |-> (!log_valid && !wr_valid && reissue_src != 2'd2));

   a_r8_poison_rsp_logged: assert property (@(posedge clk) disable iff (!rst_n)
      (!dscrub_en && rsp_valid && rsp_poison) |-> (log_valid && log_code == 5'd10));

   a_r10_poison_write_logged: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_poison) |-> (log_valid && log_code == 5'd11));

endmodule

bind ecc_resp_policy ecc_resp_policy_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dscrub_en     (dscrub_en),
   .rd_valid      (rd_valid),
   .rd_src        (rd_src),
   .rd_cls        (rd_cls),
   .rsp_valid     (rsp_valid),
   .rsp_poison    (rsp_poison),
   .wr_valid      (wr_valid),
   .wr_poison     (wr_poison),
   .reissue_valid (reissue_valid),
   .reissue_src   (reissue_src),
   .log_valid     (log_valid),
   .log_code      (log_code)
);

// File: tb/test_ecc_resp_policy.sv
module test_ecc_resp_policy;

   localparam int DW = 256;
   localparam int NT = 16;
   localparam int TW = $clog2(NT);
   localparam int RW = 3, BW = 3, OW = 16, CW = 11;
   localparam logic [DW-1:0] PSN = {{(DW-24){1'b0}}, 24'hFF00FF};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, dscrub_en, rd_valid;
   logic [1:0]    rd_src, rd_cls;
   logic [TW-1:0] rd_tag;
   logic [DW-1:0] rd_data;
   logic [RW-1:0] rd_rank;
   logic [BW-1:0] rd_bank;
   logic [OW-1:0] rd_row;
   logic [CW-1:0] rd_col;
   logic          rsp_valid, rsp_poison, wr_valid, wr_poison, reissue_valid, log_valid;
   logic [TW-1:0] rsp_tag, reissue_tag;
   logic [DW-1:0] rsp_data, wr_data;
   logic [1:0]    reissue_src;
   logic [4:0]    log_code;
   logic [RW-1:0] act_rank;
   logic [BW-1:0] act_bank;
   logic [OW-1:0] act_row;
   logic [CW-1:0] act_col;

   ecc_resp_policy i_ecc_resp_policy (
      .clk(clk), .rst_n(rst_n), .dscrub_en(dscrub_en), .rd_valid(rd_valid),
      .rd_src(rd_src), .rd_cls(rd_cls), .rd_tag(rd_tag), .rd_data(rd_data),
      .rd_rank(rd_rank), .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_poison(rsp_poison),
      .wr_valid(wr_valid), .wr_poison(wr_poison), .wr_data(wr_data),
      .reissue_valid(reissue_valid), .reissue_src(reissue_src), .reissue_tag(reissue_tag),
      .log_valid(log_valid), .log_code(log_code),
      .act_rank(act_rank), .act_bank(act_bank), .act_row(act_row), .act_col(act_col)
   );

   typedef struct {
      int            stamp;
      int            req;
      logic          wr_v, wr_p;
      logic [DW-1:0] wr_d;
      logic          ri_v;
      logic [1:0]    ri_s;
      logic [TW-1:0] ri_t;
      logic          log_v;
      logic [4:0]    code;
      logic [RW-1:0] rank;
      logic [BW-1:0] bank;
      logic [OW-1:0] row;
      logic [CW-1:0] col;
   } side_t;

   typedef struct {
      int            stamp;
      int            req;
      logic [TW-1:0] tag;
      logic [DW-1:0] data;
      logic          psn;
   } rsp_t;

   side_t side_q[$];
   rsp_t  rsp_q[$];
   bit    model_retry [NT];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    running = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic string rq(input int n);
      case (n)
         1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
         5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
         9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R?";
      endcase
   endfunction

   task automatic chk(input int req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq(req), what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk_data(input int k);
      logic [DW-1:0] d;
      for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = 32'(k * 32'h9E3779B1 + i * 32'h01010101);
      return d;
   endfunction

   // Driver: computes the expected outputs from the requirements and drives one read.
   task automatic send(input logic [1:0] src, input logic [1:0] cls, input int tag, input int k, input int req);
      side_t s;
      rsp_t  r;
      logic  uc, ce, rt, give_rsp;
      logic [DW-1:0] d;
      d  = mk_data(k);
      uc = cls[1];
      ce = (cls == 2'd1);
      rt = model_retry[tag];
      s = '{stamp: cyc + 1, req: req, wr_v: 0, wr_p: 0, wr_d: '0, ri_v: 0, ri_s: src,
            ri_t: TW'(tag), log_v: 0, code: '0, rank: RW'(k), bank: BW'(k + 1),
            row: OW'(k * 37), col: CW'(k * 5)};
      r = '{stamp: cyc + 1 + (dscrub_en ? 1 : 0), req: req, tag: TW'(tag), data: d, psn: 1'b0};
      give_rsp = 1'b0;
      if (src == 2'd0) begin
         if (!uc) begin
            give_rsp = 1'b1;
            model_retry[tag] = 1'b0;
            if (ce) begin s.log_v = 1; s.code = 5'd14; s.wr_v = dscrub_en; s.wr_d = d; end
         end else if (!rt) begin
            s.ri_v = 1; model_retry[tag] = 1'b1;
         end else begin
            give_rsp = 1'b1; r.psn = 1'b1; r.data = PSN;
            s.log_v = 1; s.code = 5'd10; model_retry[tag] = 1'b0;
         end
      end else if (src == 2'd1) begin
         if (!uc) begin
            model_retry[tag] = 1'b0;
            if (ce) begin s.wr_v = 1; s.wr_d = d; s.log_v = 1; s.code = 5'd16; end
         end else if (!rt) begin
            s.ri_v = 1; model_retry[tag] = 1'b1;
         end else begin
            s.log_v = 1; s.code = 5'd12; model_retry[tag] = 1'b0;
         end
      end else begin
         s.wr_v = 1; model_retry[tag] = 1'b0;
         if (uc) begin s.wr_p = 1; s.wr_d = PSN; s.log_v = 1; s.code = 5'd11; end
         else begin s.wr_d = d; if (ce) begin s.log_v = 1; s.code = 5'd15; end end
      end
      side_q.push_back(s);
      if (give_rsp) rsp_q.push_back(r);
      rd_valid = 1'b1; rd_src = src; rd_cls = cls; rd_tag = TW'(tag); rd_data = d;
      rd_rank = s.rank; rd_bank = s.bank; rd_row = s.row; rd_col = s.col;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      rd_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops expected items whose cycle has come, otherwise expects quiet outputs.
   always @(negedge clk) begin
      if (running) begin
         if (side_q.size() > 0 && side_q[0].stamp == cyc) begin
            side_t s;
            s = side_q.pop_front();
            chk(s.req, "wr_valid", DW'(wr_valid), DW'(s.wr_v));
            chk(s.req, "reissue_valid", DW'(reissue_valid), DW'(s.ri_v));
            chk(s.req, "log_valid", DW'(log_valid), DW'(s.log_v));
            if (s.wr_v) begin
               chk(s.req, "wr_poison", DW'(wr_poison), DW'(s.wr_p));
               chk(s.req, "wr_data", wr_data, s.wr_d);
            end
            if (s.ri_v) begin
               chk(s.req, "reissue_src", DW'(reissue_src), DW'(s.ri_s));
               chk(s.req, "reissue_tag", DW'(reissue_tag), DW'(s.ri_t));
            end
            if (s.log_v) chk(s.req, "log_code", DW'(log_code), DW'(s.code));
            if (s.wr_v || s.ri_v || s.log_v) begin
               chk(12, "act address R12", DW'({act_rank, act_bank, act_row, act_col}),
                   DW'({s.rank, s.bank, s.row, s.col}));
            end
         end else begin
            chk(1, "quiet side outputs", DW'({wr_valid, reissue_valid, log_valid}), '0);
         end
         if (rsp_q.size() > 0 && rsp_q[0].stamp == cyc) begin
            rsp_t r;
            r = rsp_q.pop_front();
            chk(r.req, "rsp_valid", DW'(rsp_valid), DW'(1));
            chk(r.req, "rsp_tag", DW'(rsp_tag), DW'(r.tag));
            chk(r.req, "rsp_poison", DW'(rsp_poison), DW'(r.psn));
            chk(r.req, "rsp_data", rsp_data, r.data);
         end else begin
            chk(1, "quiet rsp_valid", DW'(rsp_valid), '0);
         end
      end
   end

   initial begin
      #(4 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; dscrub_en = 1'b0; rd_valid = 1'b0; rd_src = '0; rd_cls = '0;
      rd_tag = '0; rd_data = '0; rd_rank = '0; rd_bank = '0; rd_row = '0; rd_col = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(1, "reset valids", DW'({rsp_valid, wr_valid, reissue_valid, log_valid}), '0);
      rst_n = 1'b1;
      running = 1'b1;
      idle(2);

      // R2 clean demand, R3 correctable demand without scrub
      send(2'd0, 2'd0, 1, 11, 2);
      send(2'd0, 2'd0, 2, 12, 2);
      send(2'd0, 2'd1, 1, 13, 3);
      // R5 patrol clean and correctable
      send(2'd1, 2'd0, 8, 14, 5);
      send(2'd1, 2'd1, 9, 15, 5);
      // R6 spare clean and correctable
      send(2'd2, 2'd0, 10, 16, 6);
      send(2'd2, 2'd1, 10, 17, 6);
      idle(2);

      // R7 then R8: demand uncorrectable, persistent
      send(2'd0, 2'd2, 3, 20, 7);
      send(2'd0, 2'd3, 3, 21, 8);
      // R7 then R9: patrol uncorrectable, persistent
      send(2'd1, 2'd2, 4, 22, 7);
      send(2'd1, 2'd2, 4, 23, 9);
      idle(1);

      // R11: per-tag retry state, clean re-read clears
      send(2'd0, 2'd2, 5, 30, 7);
      send(2'd0, 2'd2, 6, 31, 11);
      send(2'd0, 2'd0, 5, 32, 11);
      send(2'd0, 2'd2, 5, 33, 11);
      send(2'd0, 2'd1, 6, 34, 11);
      send(2'd1, 2'd2, 7, 35, 11);
      send(2'd1, 2'd1, 7, 36, 11);
      send(2'd1, 2'd2, 7, 37, 11);

      // R10: spare uncorrectable never re-issues
      send(2'd2, 2'd2, 12, 40, 10);
      send(2'd2, 2'd2, 12, 41, 10);
      idle(4);

      // R4: demand scrub enabled, extra response cycle, write-back of corrected data
      dscrub_en = 1'b1;
      idle(2);
      send(2'd0, 2'd0, 13, 50, 4);
      send(2'd0, 2'd1, 14, 51, 4);
      send(2'd0, 2'd2, 15, 52, 4);
      send(2'd0, 2'd2, 15, 53, 4);
      send(2'd1, 2'd1, 0, 54, 4);
      for (int i = 0; i < 6; i++) send(2'd0, 2'(i % 2), i, 60 + i, 4);
      idle(4);
      dscrub_en = 1'b0;
      idle(2);
      for (int i = 0; i < 6; i++) send(2'(i % 3), 2'd1, i + 8, 70 + i, 3);
      idle(4);

      chk(1, "scoreboard drained", DW'(side_q.size() + rsp_q.size()), '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule